// File: doc/BRIEF.md
# Hashed Page Table Walker

This block is the table-search engine of a 32-bit address translation unit. When a lookup starts, it takes a segment-register value and an effective address and searches an in-memory hashed page table for the page-table entry that maps the address. Each entry is 8 bytes long. Eight entries form a 64-byte group. The hash picks the group. The engine reads entries through a word-read port that allows one outstanding request at a time. If all eight entries of the primary group miss, it searches the group selected by the complemented hash. Table base and size mask come from configuration inputs and are captured when a walk starts.

On a hit the engine works out the access rights from the segment keys and the entry's page-protection field. If the requested access is allowed, it sets the entry's referenced and changed status bytes in memory through a byte-write port. It then returns the entry, its offset in the table, the real address and the permissions. The user drives a start pulse, watches `busy`, and reads the results in the cycle where `done` is high. The results stay valid until the next start.

Top module: `hpw_walker`

## Requirements
- R1: The primary group offset is ((VSID XOR page index) << 6) AND mask. VSID is seg_reg[23:0] and the page index is eff_addr[27:12]. Slot i of a group sits at base + group offset + 8*i, with word 0 at +0 and word 1 at +4. Slots are read in ascending order starting at slot 0.
- R2: A slot matches only when all three of these hold: word 0 bit 31 (valid) is 1; word 0 bit 6 (hash select) equals the pass (0 primary, 1 secondary); and word 0 bits 30:7 and 5:0 equal the VSID and eff_addr[27:22].
- R3: The secondary pass uses the complemented hash. It starts only after all 8 primary slots miss. If both passes miss, the engine reports found=0, denied=0 and all permissions 0, after exactly 16 word-0 reads.
- R4: Word 1 of a slot is read only after its word 0 has been read and has matched. rd_req stays high with a stable rd_addr until rd_ready. No read is issued while a byte write is in progress.
- R5: If word 1 bit 8 (referenced) is clear on a granted hit, the byte at entry offset + 6 is written with word1[15:8] OR 0x01.
- R6: On a granted store with word 1 bit 7 (changed) clear, the byte at entry offset + 7 is written with word1[7:0] OR 0x80, after any referenced-byte write. On a load with bit 7 clear, perm_w is reported as 0.
- R7: The key is seg_reg[29] when user_mode=1 and seg_reg[30] when user_mode=0. The page-protection field is word1[1:0]. With key 0, values 0, 1 and 2 give read-write and 3 gives read-only. With key 1, 0 gives no access, 1 and 3 give read-only, and 2 gives read-write.
- R8: perm_x is 1 unless seg_reg[28] (no-execute) is set.
- R9: real_addr is word1[31:12] joined with eff_addr[11:0]. entry_off is the hit slot's offset from the table base.
- R10: A load without read permission, or a store without write permission, gives denied=1 with found=1 and performs no byte writes.
- R11: A start is accepted only while idle. busy is high from the next cycle until done. done is high for exactly one cycle. Results hold until the next accepted start.
- R12: After reset, busy, done, rd_req and wr_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| seg_reg | input | 32 | Segment value: VSID, key and no-execute bits |
| eff_addr | input | 32 | Effective address to translate |
| is_store | input | 1 | Access is a store (else a load) |
| user_mode | input | 1 | Access is made in user state |
| tbl_base | input | 32 | Byte address of the table |
| tbl_mask | input | 32 | Mask applied to the group offset |
| rd_req | output | 1 | Word-read request |
| rd_addr | output | 32 | Word-read byte address |
| rd_ready | input | 1 | Read data valid, request complete |
| rd_data | input | 32 | Read word |
| wr_en | output | 1 | Byte-write strobe |
| wr_addr | output | 32 | Byte-write address |
| wr_data | output | 8 | Byte-write data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A matching entry was found |
| denied | output | 1 | Entry found but the access is not allowed |
| entry_w0 | output | 32 | Word 0 of the hit entry |
| entry_w1 | output | 32 | Word 1 of the hit entry as read |
| entry_off | output | 32 | Hit entry offset from the table base |
| real_addr | output | 32 | Translated real address |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |

## Verification
The assertions check the rules that can be seen on every cycle. They confirm that a pending read holds its address until it is answered, that reads and byte writes never overlap, and that done is a single-cycle pulse. They also confirm that every status-byte write carries its set bit at the right offset, that a denied result is never preceded by a write, and that a load on an unchanged page never reports write permission. Only the bench scenarios can show the search itself. Those scenarios cover the group addresses of both passes, decoy entries with the wrong hash-select bit, the wrong tag or the valid bit clear, the exact read count and order for each hit position, every key and protection combination, and the final memory bytes.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
    localparam int WORD_W       = 32;
    localparam int WORD_BYTES   = WORD_W / 8;
    localparam int ENTRY_BYTES  = 2 * WORD_BYTES;
    localparam int ENTRY_SHIFT  = $clog2(ENTRY_BYTES);
    localparam int VSID_W       = 24;
    localparam int PAGE_BITS    = 12;
    localparam int PG_IDX_W     = 16;
    localparam int API_W        = 6;
    localparam int TAG_W        = VSID_W + API_W;
    localparam int EA_KEEP_W    = PAGE_BITS + PG_IDX_W;
    localparam int RPN_W        = WORD_W - PAGE_BITS;

    // segment value fields
    localparam int SEG_NX_BIT   = 28;
    localparam int SEG_KUSR_BIT = 29;
    localparam int SEG_KSUP_BIT = 30;

    // entry word fields
    localparam int W0_VALID_BIT = 31;
    localparam int W0_HSEL_BIT  = 6;
    localparam int W1_REF_BIT   = 8;
    localparam int W1_CHG_BIT   = 7;
    localparam int PP_W         = 2;

    // status byte positions within an entry (big-endian word 1)
    localparam int REF_BYTE_OFS = 6;
    localparam int CHG_BYTE_OFS = 7;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_CHK,
        ST_WR_R,
        ST_WR_C,
        ST_FIN
    } walk_st_e;

    function automatic perm_t pp_decode(input logic key, input logic [PP_W-1:0] pp,
                                        input logic nx);
        perm_t p;
        p.ex = !nx;
        if (!key) begin
            p.rd = 1'b1;
            p.wr = (pp != 2'd3);
        end else begin
            p.rd = (pp != 2'd0);
            p.wr = (pp == 2'd2);
        end
        return p;
    endfunction
endpackage

// File: rtl/hpw_hash_gen.sv
module hpw_hash_gen
    import hpw_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8,
    localparam int IDX_W = $clog2(GROUP_ENTRIES)
) (
    input  logic [VSID_W-1:0]   vsid,
    input  logic [PG_IDX_W-1:0] pg_idx,
    input  logic [WORD_W-1:0]   base,
    input  logic [WORD_W-1:0]   mask,
    input  logic                sec_pass,
    input  logic [IDX_W-1:0]    slot,
    output logic [WORD_W-1:0]   entry_off,
    output logic [WORD_W-1:0]   w0_addr,
    output logic [WORD_W-1:0]   w1_addr,
    output logic [TAG_W-1:0]    tag
);
    localparam int GROUP_SHIFT = $clog2(GROUP_ENTRIES * ENTRY_BYTES);

    logic [WORD_W-1:0] hash;
    logic [WORD_W-1:0] hash_sel;
    logic [WORD_W-1:0] grp_off;

    always_comb begin
        hash      = WORD_W'(vsid) ^ WORD_W'(pg_idx);
        hash_sel  = sec_pass ? ~hash : hash;
        grp_off   = (hash_sel << GROUP_SHIFT) & mask;
        entry_off = grp_off + (WORD_W'(slot) << ENTRY_SHIFT);
        w0_addr   = base + entry_off;
        w1_addr   = w0_addr + WORD_W'(WORD_BYTES);
        tag       = {vsid, pg_idx[PG_IDX_W-1 -: API_W]};
    end
endmodule

// File: rtl/hpw_entry_match.sv
module hpw_entry_match
    import hpw_pkg::*;
(
    input  logic [WORD_W-1:0] w0,
    input  logic [TAG_W-1:0]  tag,
    input  logic              sec_pass,
    output logic              hit
);
    logic [TAG_W-1:0] w0_tag;

    always_comb begin
        w0_tag = {w0[W0_VALID_BIT-1:W0_HSEL_BIT+1], w0[W0_HSEL_BIT-1:0]};
        hit    = w0[W0_VALID_BIT] && (w0[W0_HSEL_BIT] == sec_pass) && (w0_tag == tag);
    end
endmodule

// File: rtl/hpw_perm_unit.sv
module hpw_perm_unit
    import hpw_pkg::*;
(
    input  logic            key_usr,
    input  logic            key_sup,
    input  logic            no_exec,
    input  logic            user,
    input  logic            is_store,
    input  logic [PP_W-1:0] pp,
    input  logic            chg,
    output perm_t           granted,
    output logic            denied
);
    logic  key;
    perm_t raw;

    always_comb begin
        key     = user ? key_usr : key_sup;
        raw     = pp_decode(key, pp, no_exec);
        denied  = is_store ? !raw.wr : !raw.rd;
        granted = raw;
        // an unchanged page stays non-writable for loads so a later store returns here
        if (!chg && !is_store) begin
            granted.wr = 1'b0;
        end
    end
endmodule

// File: rtl/hpw_walker.sv
module hpw_walker
    import hpw_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8,
    localparam int IDX_W = $clog2(GROUP_ENTRIES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [WORD_W-1:0]   seg_reg,
    input  logic [WORD_W-1:0]   eff_addr,
    input  logic                is_store,
    input  logic                user_mode,
    input  logic [WORD_W-1:0]   tbl_base,
    input  logic [WORD_W-1:0]   tbl_mask,
    output logic                rd_req,
    output logic [WORD_W-1:0]   rd_addr,
    input  logic                rd_ready,
    input  logic [WORD_W-1:0]   rd_data,
    output logic                wr_en,
    output logic [WORD_W-1:0]   wr_addr,
    output logic [7:0]          wr_data,
    output logic                busy,
    output logic                done,
    output logic                found,
    output logic                denied,
    output logic [WORD_W-1:0]   entry_w0,
    output logic [WORD_W-1:0]   entry_w1,
    output logic [WORD_W-1:0]   entry_off,
    output logic [WORD_W-1:0]   real_addr,
    output logic                perm_r,
    output logic                perm_w,
    output logic                perm_x
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(GROUP_ENTRIES - 1);

    walk_st_e               state;
    logic [VSID_W-1:0]      vsid_q;
    logic                   nx_q, kusr_q, ksup_q;
    logic [EA_KEEP_W-1:0]   ea_q;
    logic                   store_q, user_q;
    logic [WORD_W-1:0]      base_q, mask_q;
    logic                   pass_q;
    logic [IDX_W-1:0]       slot_q;
    logic [WORD_W-1:0]      w0_q, w1_q, off_q;
    logic                   found_q, denied_q;
    perm_t                  perm_q;

    logic [WORD_W-1:0]      cur_off, cur_w0_addr, cur_w1_addr;
    logic [TAG_W-1:0]       cur_tag;
    logic                   slot_hit;
    perm_t                  pu_perm;
    logic                   pu_denied;
    logic                   need_ref, need_chg;

    logic [4:0]             unused_seg;
    logic [3:0]             unused_ea;
    assign unused_seg = {seg_reg[31], seg_reg[27:24]};
    assign unused_ea  = eff_addr[WORD_W-1:EA_KEEP_W];

    hpw_hash_gen #(.GROUP_ENTRIES(GROUP_ENTRIES)) u_hash (
        .vsid      (vsid_q),
        .pg_idx    (ea_q[EA_KEEP_W-1:PAGE_BITS]),
        .base      (base_q),
        .mask      (mask_q),
        .sec_pass  (pass_q),
        .slot      (slot_q),
        .entry_off (cur_off),
        .w0_addr   (cur_w0_addr),
        .w1_addr   (cur_w1_addr),
        .tag       (cur_tag)
    );

    hpw_entry_match u_match (
        .w0       (rd_data),
        .tag      (cur_tag),
        .sec_pass (pass_q),
        .hit      (slot_hit)
    );

    hpw_perm_unit u_perm (
        .key_usr  (kusr_q),
        .key_sup  (ksup_q),
        .no_exec  (nx_q),
        .user     (user_q),
        .is_store (store_q),
        .pp       (w1_q[PP_W-1:0]),
        .chg      (w1_q[W1_CHG_BIT]),
        .granted  (pu_perm),
        .denied   (pu_denied)
    );

    assign need_ref = !w1_q[W1_REF_BIT];
    assign need_chg = store_q && !w1_q[W1_CHG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            vsid_q   <= '0;
            nx_q     <= 1'b0;
            kusr_q   <= 1'b0;
            ksup_q   <= 1'b0;
            ea_q     <= '0;
            store_q  <= 1'b0;
            user_q   <= 1'b0;
            base_q   <= '0;
            mask_q   <= '0;
            pass_q   <= 1'b0;
            slot_q   <= '0;
            w0_q     <= '0;
            w1_q     <= '0;
            off_q    <= '0;
            found_q  <= 1'b0;
            denied_q <= 1'b0;
            perm_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        vsid_q   <= seg_reg[VSID_W-1:0];
                        nx_q     <= seg_reg[SEG_NX_BIT];
                        kusr_q   <= seg_reg[SEG_KUSR_BIT];
                        ksup_q   <= seg_reg[SEG_KSUP_BIT];
                        ea_q     <= eff_addr[EA_KEEP_W-1:0];
                        store_q  <= is_store;
                        user_q   <= user_mode;
                        base_q   <= tbl_base;
                        mask_q   <= tbl_mask;
                        pass_q   <= 1'b0;
                        slot_q   <= '0;
                        w0_q     <= '0;
                        w1_q     <= '0;
                        off_q    <= '0;
                        found_q  <= 1'b0;
                        denied_q <= 1'b0;
                        perm_q   <= '0;
                        state    <= ST_RD0;
                    end
                end
                ST_RD0: begin
                    if (rd_ready) begin
                        if (slot_hit) begin
                            w0_q  <= rd_data;
                            off_q <= cur_off;
                            state <= ST_RD1;
                        end else if (slot_q == LAST_SLOT) begin
                            slot_q <= '0;
                            if (!pass_q) begin
                                pass_q <= 1'b1;
                            end else begin
                                state <= ST_FIN;
                            end
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_RD1: begin
                    if (rd_ready) begin
                        w1_q  <= rd_data;
                        state <= ST_CHK;
                    end
                end
                ST_CHK: begin
                    found_q  <= 1'b1;
                    perm_q   <= pu_perm;
                    denied_q <= pu_denied;
                    if (pu_denied) begin
                        state <= ST_FIN;
                    end else if (need_ref) begin
                        state <= ST_WR_R;
                    end else if (need_chg) begin
                        state <= ST_WR_C;
                    end else begin
                        state <= ST_FIN;
                    end
                end
                ST_WR_R: state <= need_chg ? ST_WR_C : ST_FIN;
                ST_WR_C: state <= ST_FIN;
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_req  = (state == ST_RD0) || (state == ST_RD1);
        rd_addr = (state == ST_RD1) ? cur_w1_addr : cur_w0_addr;
        wr_en   = (state == ST_WR_R) || (state == ST_WR_C);
        if (state == ST_WR_C) begin
            wr_addr = base_q + off_q + WORD_W'(CHG_BYTE_OFS);
            wr_data = w1_q[7:0] | 8'h80;
        end else begin
            wr_addr = base_q + off_q + WORD_W'(REF_BYTE_OFS);
            wr_data = w1_q[15:8] | 8'h01;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_FIN);
    assign found     = found_q;
    assign denied    = denied_q;
    assign entry_w0  = w0_q;
    assign entry_w1  = w1_q;
    assign entry_off = off_q;
    assign real_addr = {w1_q[WORD_W-1 -: RPN_W], ea_q[PAGE_BITS-1:0]};
    assign perm_r    = perm_q.rd;
    assign perm_w    = perm_q.wr;
    assign perm_x    = perm_q.ex;
endmodule

// File: rtl/hpw_walker_chk.sv
module hpw_walker_chk
    import hpw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic              denied,
    input logic              rd_req,
    input logic              rd_ready,
    input logic [WORD_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [WORD_W-1:0] base_q,
    input logic [WORD_W-1:0] entry_off,
    input logic [WORD_W-1:0] entry_w1,
    input logic              store_q,
    input logic              perm_w
);
    logic [WORD_W-1:0] wr_rel;
    assign wr_rel = wr_addr - base_q - entry_off;

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ready |=> rd_req && $stable(rd_addr));

    // R4
    no_rd_in_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !rd_req);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);

    // R12
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !busy && !done && !rd_req && !wr_en);

    // R5
    ref_byte_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_rel == WORD_W'(REF_BYTE_OFS) |-> wr_data[0]);

    // R6
    chg_byte_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_rel == WORD_W'(CHG_BYTE_OFS) |-> wr_data[7]);

    // R6
    chg_withhold_chk: assert property (@(posedge clk) disable iff (rst)
        done && found && !denied && !store_q && !entry_w1[W1_CHG_BIT] |-> !perm_w);

    // R10
    denied_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
        done && denied |-> !$past(wr_en));
endmodule

bind hpw_walker hpw_walker_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .found     (found),
    .denied    (denied),
    .rd_req    (rd_req),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .base_q    (base_q),
    .entry_off (entry_off),
    .entry_w1  (entry_w1),
    .store_q   (store_q),
    .perm_w    (perm_w)
);

// File: tb/tb_hpw_walker.sv
`timescale 1ns/1ps
module tb_hpw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] seg_reg = '0, eff_addr = '0, tbl_base = '0, tbl_mask = '0;
    logic        is_store = 1'b0, user_mode = 1'b0;
    logic        rd_req, rd_ready, wr_en, busy, done, found, denied, perm_r, perm_w, perm_x;
    logic [31:0] rd_addr, rd_data, wr_addr, entry_w0, entry_w1, entry_off, real_addr;
    logic [7:0]  wr_data;

    always #2.5 clk = ~clk;

    hpw_walker dut (
        .clk(clk), .rst(rst), .start(start), .seg_reg(seg_reg), .eff_addr(eff_addr),
        .is_store(is_store), .user_mode(user_mode), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
        .found(found), .denied(denied), .entry_w0(entry_w0), .entry_w1(entry_w1),
        .entry_off(entry_off), .real_addr(real_addr), .perm_r(perm_r), .perm_w(perm_w),
        .perm_x(perm_x)
    );

    localparam logic [31:0] BASE = 32'h0010_0000;

    // ---------------- memory model ----------------
    logic [31:0] mem [int unsigned];
    int          lat = 0;
    int          lat_cnt = 0;
    logic [31:0] rd_log [0:31];
    int          rd_cnt = 0;
    logic [31:0] wr_log_a [0:7];
    logic [7:0]  wr_log_d [0:7];
    int          wr_cnt = 0;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        int unsigned k;
        k = a >> 2;
        return mem.exists(k) ? mem[k] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            rd_ready <= 1'b0;
            rd_data  <= '0;
            lat_cnt  = 0;
        end else begin
            if (rd_req && !rd_ready) begin
                if (lat_cnt >= lat) begin
                    rd_ready <= 1'b1;
                    rd_data  <= mem_rd(rd_addr);
                    if (rd_cnt < 32) rd_log[rd_cnt] = rd_addr;
                    rd_cnt++;
                    lat_cnt = 0;
                end else begin
                    lat_cnt++;
                end
            end else begin
                rd_ready <= 1'b0;
            end
            if (wr_en) begin
                logic [31:0] w;
                int unsigned k;
                int          sh;
                k  = wr_addr >> 2;
                w  = mem_rd(wr_addr);
                sh = 24 - 8 * int'(wr_addr[1:0]);
                w  = (w & ~(32'hFF << sh)) | (32'(wr_data) << sh);
                mem[k] = w;
                if (wr_cnt < 8) begin
                    wr_log_a[wr_cnt] = wr_addr;
                    wr_log_d[wr_cnt] = wr_data;
                end
                wr_cnt++;
            end
        end
    end

    // ---------------- checking ----------------
    int total = 0;
    int bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] grp_of(input logic [31:0] seg, input logic [31:0] ea,
                                           input logic [31:0] mask, input logic sec);
        logic [31:0] h;
        h = {8'h0, seg[23:0]} ^ {16'h0, ea[27:12]};
        if (sec) h = ~h;
        return (h << 6) & mask;
    endfunction

    function automatic logic [31:0] mk_w0(input logic v, input logic [23:0] vsid,
                                          input logic hs, input logic [5:0] api);
        return {v, vsid, hs, api};
    endfunction

    task automatic put(input logic [31:0] off, input logic [31:0] w0, input logic [31:0] w1);
        mem[(BASE + off) >> 2]       = w0;
        mem[(BASE + off + 4) >> 2]   = w1;
    endtask

    logic [31:0] s_w0, s_w1, s_off, s_real;
    logic        s_found, s_den, s_r, s_w, s_x;

    task automatic walk(input logic [31:0] seg, input logic [31:0] ea, input logic st,
                        input logic usr, input logic [31:0] mask);
        int n;
        @(negedge clk);
        seg_reg = seg; eff_addr = ea; is_store = st; user_mode = usr;
        tbl_base = BASE; tbl_mask = mask;
        rd_cnt = 0; wr_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R11 walk completes", {31'h0, done}, 32'h1);
        s_found = found; s_den = denied; s_w0 = entry_w0; s_w1 = entry_w1;
        s_off = entry_off; s_real = real_addr; s_r = perm_r; s_w = perm_w; s_x = perm_x;
        @(negedge clk);
        check("R11 done single cycle", {31'h0, done}, 32'h0);
        check("R11 result held", {31'h0, found}, {31'h0, s_found});
    endtask

    typedef struct packed {
        logic [31:0] seg;
        logic [31:0] ea;
        logic        st;
        logic        usr;
        logic [31:0] mask;
        logic [1:0]  pass;   // 0 primary, 1 secondary, 2 none
        logic [2:0]  slot;
        logic [1:0]  pp;
        logic        r;
        logic        c;
        logic [2:0]  eperm;  // {r,w,x}
        logic        eden;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1234, 32'h0ABC_D123, 1'b0, 1'b0, 32'h0000_FFC0, 2'd0, 3'd0, 2'd2, 1'b0, 1'b0, 3'b101, 1'b0},
        '{32'h4000_0055, 32'h1234_5678, 1'b1, 1'b0, 32'h0000_FFC0, 2'd1, 3'd3, 2'd2, 1'b1, 1'b0, 3'b111, 1'b0},
        '{32'h2000_0055, 32'h3000_1FFC, 1'b0, 1'b1, 32'h0000_03C0, 2'd0, 3'd1, 2'd0, 1'b0, 1'b0, 3'b001, 1'b1},
        '{32'h1000_00AA, 32'h0000_0ABC, 1'b0, 1'b0, 32'h0000_FFC0, 2'd0, 3'd7, 2'd3, 1'b1, 1'b1, 3'b100, 1'b0},
        '{32'h6000_0F0F, 32'h7FFF_F004, 1'b1, 1'b1, 32'h0000_FFC0, 2'd1, 3'd7, 2'd1, 1'b0, 1'b0, 3'b101, 1'b1},
        '{32'h4000_0001, 32'h0400_0010, 1'b0, 1'b0, 32'h0000_FFC0, 2'd0, 3'd4, 2'd3, 1'b0, 1'b1, 3'b101, 1'b0},
        '{32'h0000_0777, 32'h0BAD_F00D, 1'b1, 1'b0, 32'h0000_FFC0, 2'd1, 3'd0, 2'd1, 1'b0, 1'b0, 3'b111, 1'b0},
        '{32'h00AB_CDEF, 32'h0123_4567, 1'b0, 1'b0, 32'h0000_03C0, 2'd2, 3'd0, 2'd0, 1'b0, 1'b0, 3'b000, 1'b0},
        '{32'h2000_0033, 32'h0000_5000, 1'b0, 1'b0, 32'h0000_FFC0, 2'd0, 3'd3, 2'd0, 1'b1, 1'b1, 3'b111, 1'b0}
    };

    task automatic place(input vec_t v, output logic [31:0] hit_off, output logic [31:0] hit_w1);
        logic [31:0] gp, gs;
        logic [23:0] vs;
        logic [5:0]  api;
        vs  = v.seg[23:0];
        api = v.ea[27:22];
        gp  = grp_of(v.seg, v.ea, v.mask, 1'b0);
        gs  = grp_of(v.seg, v.ea, v.mask, 1'b1);
        mem.delete();
        // decoys: wrong tag, wrong hash select, valid clear
        put(gp + 32'd16, mk_w0(1'b1, vs, 1'b0, api ^ 6'h01), 32'hDEAD_0102);
        put(gp + 32'd40, mk_w0(1'b1, vs, 1'b1, api), 32'hDEAD_0202);
        put(gp + 32'd48, mk_w0(1'b0, vs, 1'b0, api), 32'hDEAD_0302);
        put(gs + 32'd8,  mk_w0(1'b1, vs, 1'b0, api), 32'hDEAD_0402);
        put(gs + 32'd32, mk_w0(1'b1, vs ^ 24'h1, 1'b1, api), 32'hDEAD_0502);
        hit_w1  = {20'hA5C30 ^ {17'h0, v.slot}, 3'b0, v.r, v.c, 5'b0, v.pp};
        hit_off = ((v.pass == 2'd1) ? gs : gp) + {26'h0, v.slot, 3'b000};
        if (v.pass != 2'd2) begin
            put(hit_off, mk_w0(1'b1, vs, v.pass[0], api), hit_w1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] hoff, hw1, exp_w1;
        int          exp_rd, exp_wr;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 busy after reset", {31'h0, busy}, 32'h0);
        check("R12 done after reset", {31'h0, done}, 32'h0);
        check("R12 rd_req after reset", {31'h0, rd_req}, 32'h0);
        check("R12 wr_en after reset", {31'h0, wr_en}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 idle after reset release", {30'h0, busy, rd_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            lat = i % 3;
            place(v, hoff, hw1);
            walk(v.seg, v.ea, v.st, v.usr, v.mask);
            // R1: first read is slot 0 of the primary group
            check($sformatf("R1 v%0d first read", i), rd_log[0],
                  BASE + grp_of(v.seg, v.ea, v.mask, 1'b0));
            check($sformatf("R1 v%0d second read", i), rd_log[1],
                  (v.pass == 2'd0 && v.slot == 3'd0) ? BASE + hoff + 32'd4
                  : BASE + grp_of(v.seg, v.ea, v.mask, 1'b0) + 32'd8);
            if (v.pass == 2'd2) begin
                // R3: no hit in either pass
                check($sformatf("R3 v%0d found", i), {31'h0, s_found}, 32'h0);
                check($sformatf("R3 v%0d denied", i), {31'h0, s_den}, 32'h0);
                check($sformatf("R3 v%0d perms", i), {29'h0, s_r, s_w, s_x}, 32'h0);
                check($sformatf("R3 v%0d read count", i), rd_cnt, 32'd16);
                check($sformatf("R3 v%0d secondary start", i), rd_log[8],
                      BASE + grp_of(v.seg, v.ea, v.mask, 1'b1));
                check($sformatf("R10 v%0d no writes", i), wr_cnt, 32'd0);
                continue;
            end
            exp_rd = (v.pass == 2'd1) ? 8 + int'(v.slot) + 2 : int'(v.slot) + 2;
            check($sformatf("R2 v%0d found", i), {31'h0, s_found}, 32'h1);
            check($sformatf("R3 v%0d read count", i), rd_cnt, exp_rd);
            if (v.pass == 2'd1) begin
                check($sformatf("R3 v%0d secondary start", i), rd_log[8],
                      BASE + grp_of(v.seg, v.ea, v.mask, 1'b1));
            end
            // R4: word 0 then word 1 of the hit entry, last two reads
            check($sformatf("R4 v%0d w0 before w1", i), rd_log[exp_rd - 2], BASE + hoff);
            check($sformatf("R4 v%0d w1 last", i), rd_log[exp_rd - 1], BASE + hoff + 32'd4);
            check($sformatf("R9 v%0d entry_off", i), s_off, hoff);
            check($sformatf("R9 v%0d real_addr", i), s_real, {hw1[31:12], v.ea[11:0]});
            check($sformatf("R2 v%0d entry_w1", i), s_w1, hw1);
            check($sformatf("R2 v%0d entry_w0 tag", i), s_w0,
                  mk_w0(1'b1, v.seg[23:0], v.pass[0], v.ea[27:22]));
            check($sformatf("R7 R8 v%0d perms", i), {29'h0, s_r, s_w, s_x}, {29'h0, v.eperm});
            check($sformatf("R10 v%0d denied", i), {31'h0, s_den}, {31'h0, v.eden});
            exp_wr = 0;
            if (!v.eden && !v.r) begin
                check($sformatf("R5 v%0d ref addr", i), wr_log_a[exp_wr], BASE + hoff + 32'd6);
                check($sformatf("R5 v%0d ref data", i), {24'h0, wr_log_d[exp_wr]},
                      {24'h0, hw1[15:8] | 8'h01});
                exp_wr++;
            end
            if (!v.eden && v.st && !v.c) begin
                check($sformatf("R6 v%0d chg addr", i), wr_log_a[exp_wr], BASE + hoff + 32'd7);
                check($sformatf("R6 v%0d chg data", i), {24'h0, wr_log_d[exp_wr]},
                      {24'h0, hw1[7:0] | 8'h80});
                exp_wr++;
            end
            check($sformatf("R5 R6 R10 v%0d write count", i), wr_cnt, exp_wr);
            exp_w1 = hw1;
            if (!v.eden) begin
                exp_w1[8] = 1'b1;
                if (v.st) exp_w1[7] = 1'b1;
            end
            check($sformatf("R5 R6 v%0d memory word1", i), mem_rd(BASE + hoff + 32'd4), exp_w1);
        end

        // R11: start while busy is ignored
        begin
            vec_t v;
            v = VECS[0];
            lat = 2;
            place(v, hoff, hw1);
            @(negedge clk);
            seg_reg = v.seg; eff_addr = v.ea; is_store = v.st; user_mode = v.usr;
            tbl_base = BASE; tbl_mask = v.mask;
            rd_cnt = 0; wr_cnt = 0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            check("R11 busy mid walk", {31'h0, busy}, 32'h1);
            eff_addr = 32'h0FFF_F777;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int n = 0; n < 200 && !done; n++) @(negedge clk);
            check("R11 second start ignored", real_addr, {hw1[31:12], v.ea[11:0]});
            @(negedge clk);
            check("R11 idle after walk", {31'h0, busy}, 32'h0);
            check("R11 result held while idle", real_addr, {hw1[31:12], v.ea[11:0]});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule